// File: doc/BRIEF.md
# Timer/Counter with DAC Update Control

This block holds an 8-bit control register that the host can write but cannot read back. The register sets up a 16-bit down-counter and decides when a digital-to-analog converter output latch takes new data. The counter is clocked by an internal 1 MHz tick, divided down from the system clock, or by rising edges on an external clock pin. It has four run modes: reload, pause, go, and go only while an external gate pin is high. When the counter wraps it raises a one-cycle overflow pulse and sets a sticky overflow latch. The interrupt output is that latch, masked by an enable bit.

The DAC side is a two-state machine. In state `DS_IDLE` no data is waiting. In state `DS_PENDING` a written word is held until its release event.
- *hold*: a data write moves `DS_IDLE` to `DS_PENDING` in any event-driven update mode.
- *release*: the selected event (counter overflow, gate rising edge or pacer pulse) moves `DS_PENDING` back to `DS_IDLE` and drives the held word out.
- *flush*: selecting direct update while in `DS_PENDING` releases the held word straight away.
- *direct write*: in direct mode a write stays in or returns to `DS_IDLE` and updates the output in the next cycle.

Two further register bits, the analog-trigger select and the pre-trigger option, are passed out as plain level outputs.

Top module: `tmr_dac_ctl`

## Requirements
- R1: After reset every output is 0. The control register reset value is zero: direct DAC update, reload mode, internal clock, interrupt disabled.
- R2: Control bit 7 appears on `trig_src_analog` (1 = analog, 0 = TTL) and bit 6 appears on `pretrig_en`, in the cycle after the write.
- R3: With bits [4:3] = 00 (reload), `count` equals the preset register, one cycle after the preset register changes.
- R4: With bits [4:3] = 10 (go), each selected clock event decrements `count`. An event at count 0 reloads the preset and raises `ovf_pulse` for exactly one cycle, so one period spans preset+1 events.
- R5: With bits [4:3] = 01 (pause), `count` holds its value.
- R6: With bits [4:3] = 11, counting occurs only while the synchronized `ext_gate_in` is high.
- R7: Bit 2 selects the clock. With 0, an internal tick occurs every TICK_DIV system cycles. With 1, each rising edge of `ext_clk_in` counts after a two-flop synchronizer, so it is acted on at the third system clock edge after the pin rises.
- R8: A wrap sets the overflow latch. A control write with bit 5 = 0 clears the latch, but a wrap in the same cycle wins. `irq` = latch AND bit 5.
- R9: With bits [1:0] = 00 (direct), `dac_out` takes the written data and `dac_update` pulses in the cycle after the write. Selecting direct mode while data is pending flushes that data the same way.
- R10: With bits [1:0] = 01, pending data is applied in the cycle after `ovf_pulse`.
- R11: With bits [1:0] = 10, pending data is applied on a synchronized rising edge of `ext_gate_in`.
- R12: With bits [1:0] = 11, pending data is applied on a `pacer_tick` pulse. In any event mode, an event with no data pending gives no strobe, and a write in the event cycle is applied at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| preset_we | input | 1 | Preset register write strobe |
| preset_wdata | input | CNT_W | Preset value |
| dac_we | input | 1 | DAC data write strobe |
| dac_wdata | input | DAT_W | DAC data word |
| ext_clk_in | input | 1 | Asynchronous external counter clock |
| ext_gate_in | input | 1 | Asynchronous external gate |
| pacer_tick | input | 1 | Single-cycle pacer pulse, system clock domain |
| count | output | CNT_W | Current counter value |
| ovf_pulse | output | 1 | One-cycle wrap pulse |
| irq | output | 1 | Masked overflow interrupt |
| dac_out | output | DAT_W | DAC output latch |
| dac_update | output | 1 | One-cycle strobe when `dac_out` changes |
| trig_src_analog | output | 1 | Trigger source select |
| pretrig_en | output | 1 | Pre-trigger option enable |

## Verification
The bench clears the latch with a write in the exact cycle of a wrap. A design that lets the clear win loses an interrupt. It also fires pacer and gate events with nothing pending, and a design that strobes on a bare event would corrupt the DAC output timing. A write in the same cycle as an event must go out at once; if the design keeps it pending instead, its output lags by one full event period. Switching to direct mode while a word is held must flush the word, and a design that drops it leaves `dac_out` stale. External clock edges and gated counting also check the synchronizer depth: one flop too few or too many shifts every count by a cycle against the per-cycle reference.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        CM_RELOAD = 2'b00,
        CM_PAUSE  = 2'b01,
        CM_GO     = 2'b10,
        CM_GATED  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        DU_DIRECT    = 2'b00,
        DU_OVERFLOW  = 2'b01,
        DU_GATE_RISE = 2'b10,
        DU_PACER     = 2'b11
    } dac_src_e;

    typedef enum logic {
        DS_IDLE    = 1'b0,
        DS_PENDING = 1'b1
    } dac_state_e;

    // bit 7 first: packed struct order matches the register layout
    typedef struct packed {
        logic      trig_analog;
        logic      pretrig;
        logic      irq_en;
        cnt_mode_e mode;
        logic      ext_clk_sel;
        dac_src_e  dac_src;
    } ctrl_reg_t;

endpackage

// File: rtl/tdc_sync.sv
module tdc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], async_in};
    end

    assign level = sh_q[1];
    assign rise  = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tdc_counter.sv
module tdc_counter
    import tdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic             src_tick,
    input  logic             gate_lvl,
    input  logic [CNT_W-1:0] preset,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             ovf_latch
);
    logic             step;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        step = 1'b0;
        unique case (mode)
            CM_RELOAD: step = 1'b0;
            CM_PAUSE:  step = 1'b0;
            CM_GO:     step = src_tick;
            CM_GATED:  step = src_tick & gate_lvl;
        endcase
    end

    assign wrap = step && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_pulse <= 1'b0;
            ovf_latch <= 1'b0;
        end else begin
            if (mode == CM_RELOAD || wrap) cnt_q <= preset;
            else if (step)                 cnt_q <= cnt_q - 1'b1;
            ovf_pulse <= wrap;
            if (wrap)         ovf_latch <= 1'b1;
            else if (clr_req) ovf_latch <= 1'b0;
        end
    end

    assign count = cnt_q;

    a_r5_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_PAUSE) |=> (count == $past(count)));

    a_r3_reload_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_RELOAD) |=> (count == $past(preset)));

    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == $past(preset)));

    a_r8_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_latch);
endmodule

// File: rtl/tdc_dac_ctl.sv
module tdc_dac_ctl
    import tdc_pkg::*;
#(
    parameter int DAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dac_src_e         src,
    input  logic             dac_we,
    input  logic [DAT_W-1:0] dac_wdata,
    input  logic             ovf_evt,
    input  logic             gate_rise,
    input  logic             pacer,
    output logic [DAT_W-1:0] dac_out,
    output logic             dac_update
);
    dac_state_e       st_q, st_d;
    logic [DAT_W-1:0] hold_q;
    logic             evt;
    logic             load;
    logic [DAT_W-1:0] load_val;

    always_comb begin
        evt = 1'b0;
        unique case (src)
            DU_DIRECT:    evt = 1'b0;
            DU_OVERFLOW:  evt = ovf_evt;
            DU_GATE_RISE: evt = gate_rise;
            DU_PACER:     evt = pacer;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        load_val = hold_q;
        if (src == DU_DIRECT) begin
            if (dac_we) begin
                load     = 1'b1;
                load_val = dac_wdata;
                st_d     = DS_IDLE;
            end else if (st_q == DS_PENDING) begin
                load = 1'b1;
                st_d = DS_IDLE;
            end
        end else if (evt && (dac_we || st_q == DS_PENDING)) begin
            load     = 1'b1;
            load_val = dac_we ? dac_wdata : hold_q;
            st_d     = DS_IDLE;
        end else if (dac_we) begin
            st_d = DS_PENDING;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DS_IDLE;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (dac_we) hold_q <= dac_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_out    <= '0;
            dac_update <= 1'b0;
        end else begin
            dac_update <= load;
            if (load) dac_out <= load_val;
        end
    end

    a_r9_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
        (src == DU_DIRECT && dac_we) |=> (dac_update && dac_out == $past(dac_wdata)));

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_we && st_q == DS_IDLE) |=> !dac_update);
endmodule

// File: rtl/tmr_dac_ctl.sv
module tmr_dac_ctl
    import tdc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DAT_W    = 12,
    parameter int TICK_DIV = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_wdata,
    input  logic             dac_we,
    input  logic [DAT_W-1:0] dac_wdata,
    input  logic             ext_clk_in,
    input  logic             ext_gate_in,
    input  logic             pacer_tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             irq,
    output logic [DAT_W-1:0] dac_out,
    output logic             dac_update,
    output logic             trig_src_analog,
    output logic             pretrig_en
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    ctrl_reg_t        ctrl_q;
    logic [CNT_W-1:0] preset_q;
    logic [DIV_W-1:0] div_q;
    logic             tick_int;
    logic             clk_lvl, clk_rise, gate_lvl, gate_rise;
    logic             src_tick;
    logic             ovf_latch;
    logic             clr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            preset_q <= '0;
            div_q    <= '0;
        end else begin
            if (cfg_we)    ctrl_q   <= ctrl_reg_t'(cfg_wdata);
            if (preset_we) preset_q <= preset_wdata;
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign tick_int = (div_q == DIV_LAST);
    assign src_tick = ctrl_q.ext_clk_sel ? clk_rise : tick_int;
    assign clr_req  = cfg_we & ~cfg_wdata[5];

    tdc_sync u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in),
        .level(clk_lvl), .rise(clk_rise)
    );

    tdc_sync u_sync_gate (
        .clk(clk), .rst_n(rst_n), .async_in(ext_gate_in),
        .level(gate_lvl), .rise(gate_rise)
    );

    tdc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .src_tick(src_tick),
        .gate_lvl(gate_lvl), .preset(preset_q), .clr_req(clr_req),
        .count(count), .ovf_pulse(ovf_pulse), .ovf_latch(ovf_latch)
    );

    tdc_dac_ctl #(.DAT_W(DAT_W)) u_dac (
        .clk(clk), .rst_n(rst_n), .src(ctrl_q.dac_src), .dac_we(dac_we),
        .dac_wdata(dac_wdata), .ovf_evt(ovf_pulse), .gate_rise(gate_rise),
        .pacer(pacer_tick), .dac_out(dac_out), .dac_update(dac_update)
    );

    assign irq             = ovf_latch & ctrl_q.irq_en;
    assign trig_src_analog = ctrl_q.trig_analog;
    assign pretrig_en      = ctrl_q.pretrig;

    // clk_lvl is only used for edge detection
    logic unused_lvl;
    assign unused_lvl = clk_lvl;

    a_r2_export_bits: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (trig_src_analog == $past(cfg_wdata[7]) && pretrig_en == $past(cfg_wdata[6])));

    a_r8_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[5]) |=> !irq);
endmodule

// File: tb/tmr_dac_ctl_tb.sv
module tmr_dac_ctl_tb;
    localparam int DIV = 4;
    localparam int CW  = 16;
    localparam int DW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic          preset_we = 1'b0;
    logic [CW-1:0] preset_wdata = '0;
    logic          dac_we = 1'b0;
    logic [DW-1:0] dac_wdata = '0;
    logic          ext_clk_in = 1'b0;
    logic          ext_gate_in = 1'b0;
    logic          pacer_tick = 1'b0;
    logic [CW-1:0] count;
    logic          ovf_pulse, irq, dac_update, trig_src_analog, pretrig_en;
    logic [DW-1:0] dac_out;

    int checks = 0;
    int errors = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    tmr_dac_ctl #(.CNT_W(CW), .DAT_W(DW), .TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .preset_we(preset_we), .preset_wdata(preset_wdata),
        .dac_we(dac_we), .dac_wdata(dac_wdata),
        .ext_clk_in(ext_clk_in), .ext_gate_in(ext_gate_in), .pacer_tick(pacer_tick),
        .count(count), .ovf_pulse(ovf_pulse), .irq(irq), .dac_out(dac_out),
        .dac_update(dac_update), .trig_src_analog(trig_src_analog), .pretrig_en(pretrig_en)
    );

    // behavioural reference, one step per clock
    int m_ctrl, m_preset, m_cnt, m_pulse, m_latch, m_div;
    int c1, c2, c3, g1, g2, g3;
    int m_pend, m_hold, m_dout, m_upd;

    always @(posedge clk) begin
        int tick, src, mode, step, wrap, ncnt, evt, dm;
        if (!rst_n) begin
            m_ctrl = 0; m_preset = 0; m_cnt = 0; m_pulse = 0; m_latch = 0; m_div = 0;
            c1 = 0; c2 = 0; c3 = 0; g1 = 0; g2 = 0; g3 = 0;
            m_pend = 0; m_hold = 0; m_dout = 0; m_upd = 0;
        end else begin
            tick = (m_div == DIV - 1);
            src  = ((m_ctrl >> 2) & 1) ? (c2 && !c3) : tick;
            mode = (m_ctrl >> 3) & 3;
            step = src && (mode == 2 || (mode == 3 && g2 == 1));
            wrap = step && (m_cnt == 0);
            if (mode == 0 || wrap) ncnt = m_preset;
            else if (step)         ncnt = m_cnt - 1;
            else                   ncnt = m_cnt;
            dm = m_ctrl & 3;
            evt = (dm == 1) ? m_pulse : (dm == 2) ? (g2 && !g3) : (dm == 3) ? pacer_tick : 0;
            m_upd = 0;
            if (dm == 0) begin
                if (dac_we) begin m_dout = dac_wdata; m_upd = 1; m_pend = 0; end
                else if (m_pend) begin m_dout = m_hold; m_upd = 1; m_pend = 0; end
            end else if (evt && (dac_we || m_pend)) begin
                m_dout = dac_we ? int'(dac_wdata) : m_hold; m_upd = 1; m_pend = 0;
            end else if (dac_we) m_pend = 1;
            if (dac_we) m_hold = dac_wdata;
            if (wrap) m_latch = 1;
            else if (cfg_we && !cfg_wdata[5]) m_latch = 0;
            m_pulse = wrap;
            m_cnt = ncnt;
            if (cfg_we) m_ctrl = cfg_wdata;
            if (preset_we) m_preset = preset_wdata;
            m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            c3 = c2; c2 = c1; c1 = ext_clk_in;
            g3 = g2; g2 = g1; g1 = ext_gate_in;
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking && rst_n) begin
            cmp("count", count, m_cnt);
            cmp("ovf_pulse", ovf_pulse, m_pulse);
            cmp("irq", irq, m_latch & ((m_ctrl >> 5) & 1));
            cmp("dac_update", dac_update, m_upd);
            cmp("dac_out", dac_out, m_dout);
            cmp("trig_src_analog", trig_src_analog, (m_ctrl >> 7) & 1);
            cmp("pretrig_en", pretrig_en, (m_ctrl >> 6) & 1);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wr_preset(int v);
        @(negedge clk); preset_we = 1'b1; preset_wdata = CW'(v);
        @(negedge clk); preset_we = 1'b0;
    endtask

    task automatic wr_dac(int v);
        @(negedge clk); dac_we = 1'b1; dac_wdata = DW'(v);
        @(negedge clk); dac_we = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        cmp("reset count", count, 0);
        cmp("reset dac_out", dac_out, 0);
        cmp("reset irq", irq, 0);
        cmp("reset trig", trig_src_analog, 0);
        checking = 1'b1;
        idle(3);

        cur_req = "R2"; wr_cfg(8'hC0); idle(2); wr_cfg(8'h40); idle(2); wr_cfg(8'h00);
        cur_req = "R3"; wr_preset(5); idle(3); wr_preset(9); idle(3); wr_preset(5);
        cur_req = "R4"; wr_cfg(8'h10); idle(40);
        cur_req = "R8"; wr_cfg(8'h30); idle(30); wr_cfg(8'h10); idle(3); wr_cfg(8'h30); idle(25);
        cur_req = "R5"; wr_cfg(8'h28); idle(20);
        cur_req = "R6"; wr_cfg(8'h38); idle(8);
        ext_gate_in = 1'b1; idle(17); ext_gate_in = 1'b0; idle(15);
        ext_gate_in = 1'b1; idle(30); ext_gate_in = 1'b0;
        cur_req = "R7"; wr_cfg(8'h34);
        for (int i = 0; i < 30; i++) begin
            ext_clk_in = 1'b1; idle(2); ext_clk_in = 1'b0; idle(1);
        end
        cur_req = "R8"; wr_preset(1); wr_cfg(8'h30); idle(4);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); cfg_we = 1'b1; cfg_wdata = (i % 2 == 0) ? 8'h10 : 8'h30;
        end
        @(negedge clk); cfg_we = 1'b0;
        idle(5);

        cur_req = "R9"; wr_preset(4); wr_cfg(8'h10); wr_dac(12'h123); idle(2); wr_dac(12'hABC); idle(3);
        cur_req = "R10"; wr_cfg(8'h11); wr_dac(12'h456); idle(30);
        cur_req = "R11"; wr_cfg(8'h12); idle(4); ext_gate_in = 1'b1; idle(6); ext_gate_in = 1'b0;
        wr_dac(12'h789); idle(5); ext_gate_in = 1'b1; idle(6); ext_gate_in = 1'b0; idle(4);
        cur_req = "R12"; wr_cfg(8'h13);
        @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0; idle(3);
        wr_dac(12'h321); idle(3);
        @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0; idle(3);
        @(negedge clk); pacer_tick = 1'b1; dac_we = 1'b1; dac_wdata = 12'h0F0;
        @(negedge clk); pacer_tick = 1'b0; dac_we = 1'b0; idle(3);
        cur_req = "R9"; wr_dac(12'h5A5); idle(3); wr_cfg(8'h10); idle(4);

        checking = 1'b0;
        done = 1'b1;
        report();
    end
endmodule